// File: doc/BRIEF.md
# Interline CCD Clock Sequencer

This block produces the digital timing that drives a progressive-scan interline CCD. It runs from one master clock whose rate is a parameterised multiple of the pixel rate. Its outputs are logic-level enables: two vertical phases, two horizontal phases and the reset gate. External level shifters turn them into sensor voltages. A separate enable selects the high photodiode-transfer level of vertical phase 2.

The frame is a fixed number of lines. The first line of each frame is a photodiode-transfer line. On that line vertical phase 2 is raised to its high level for a programmable pulse, with a quiet pedestal before and after it. No pixels are read out on that line. Every other line opens with a retrace window. Inside that window vertical phase 1 rises and phase 2 falls, for a set interval, to move one row into the horizontal register. Phase 1 then returns low, and a set delay passes before horizontal clocking starts.

The readout that follows shifts a fixed number of pixels. Each pixel lasts a set number of master ticks, and the reset gate pulses at the start of the phase-2 half of each pixel. The block also gives capture logic a frame-start strobe, a line-valid flag, the pixel number and the line number. A synchronous reset returns every output to its idle level. All counts are parameters.

Top module: `ccd_clk_seq`

## Requirements
- R1: While `srst` is high, and on the first clock edge at which it is sampled high, the outputs go to idle: v1 0, v2_on 1, v2_hi 0, h1 1, h2 0, rg 0, frame_start 0, line_valid 0, pixel_index 0, line_index 0.
- R2: A line is RETRACE + H_PIX*TPP ticks long. line_index counts from 0 to FRAME_LINES-1 and wraps. frame_start is high for exactly one tick, the first tick of line 0. Outputs are registered: the first edge after `srst` is released shows line 0, tick 0.
- R3: On lines other than 0, v1 is 1 and v2_on is 0 for VT ticks, starting VD ticks into the line. At all other times v1 is 0 and v2_on is 1. v1 is always the complement of v2_on.
- R4: On line 0, v2_hi is 1 for VH ticks starting PED ticks into the line, and is never 1 anywhere else. v2_on stays 1 on line 0, and line 0 has no horizontal readout.
- R5: On lines other than 0, readout starts RETRACE ticks into the line and covers H_PIX pixels of TPP ticks each. In each pixel, h1 is 1 for the first TPP/2 ticks and h2 is 1 for the rest. h1 is always the complement of h2. Outside readout, h1 is 1 and h2 is 0.
- R6: rg is 1 for RST_W ticks, beginning on the tick where h2 rises, and only during readout.
- R7: line_valid is 1 exactly on readout ticks. pixel_index gives the pixel number, 0 to H_PIX-1, during readout and is 0 otherwise.
- R8: Horizontal clocking never happens while v1 is 1. At least HD ticks pass between v1 falling and the first readout tick.
- R9: Parameter combinations that break the timing rules are rejected at elaboration: an odd TPP, an RST_W outside 1..TPP/2, VD+VT+HD above RETRACE, or 2*PED+VH above the line length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, TPP ticks per pixel |
| srst | input | 1 | Synchronous reset, active high |
| v1_on_o | output | 1 | Vertical phase 1 high-level enable |
| v2_on_o | output | 1 | Vertical phase 2 enable (mid level) |
| v2_hi_o | output | 1 | Vertical phase 2 transfer (high) level enable |
| h1_on_o | output | 1 | Horizontal phase 1 enable |
| h2_on_o | output | 1 | Horizontal phase 2 enable |
| rg_on_o | output | 1 | Reset gate enable |
| frame_start_o | output | 1 | One-tick strobe at the start of each frame |
| line_valid_o | output | 1 | High during horizontal readout ticks |
| pixel_index_o | output | $clog2(H_PIX) | Pixel number within the readout |
| line_index_o | output | $clog2(FRAME_LINES) | Line number within the frame |

## Verification
A wrong tick or line count shows up as a shifted vertical transfer window or a shifted readout start on the very next line, so a per-tick reference comparison catches it within one line time. A horizontal sub-pixel counter that drifts out of step shows up at once as a wrong h1/h2 or reset-gate pattern, or as a pixel number jumping by more than one. A fault in the photodiode-transfer pulse appears only on line 0. The bench therefore runs more than two whole frames and also measures the pulse width and the frame period as totals. A reset applied in mid-line checks that no stale counter state leaks into the next frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   typedef struct packed {
      logic v1;
      logic v2_on;
      logic v2_hi;
   } vphase_t;

   typedef struct packed {
      logic h1;
      logic h2;
      logic rg;
   } hphase_t;

   // Idle levels: row held under phase 2, charge held under horizontal phase 1
   localparam vphase_t V_IDLE = '{v1: 1'b0, v2_on: 1'b1, v2_hi: 1'b0};
   localparam hphase_t H_IDLE = '{h1: 1'b1, h2: 1'b0, rg: 1'b0};

endpackage

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
   parameter int LINE_TICKS  = 3644,
   parameter int FRAME_LINES = 525,
   parameter int RETRACE     = 480,
   localparam int TICK_W     = $clog2(LINE_TICKS),
   localparam int LINE_W     = $clog2(FRAME_LINES)
) (
   input  logic              clk,
   input  logic              srst,
   output logic [TICK_W-1:0] tick_o,
   output logic              xfer_line_o,
   output logic              readout_o,
   output logic              frame_start_o,
   output logic [LINE_W-1:0] line_index_o
);

   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(LINE_TICKS - 1);
   localparam logic [TICK_W-1:0] RET_T     = TICK_W'(RETRACE);
   localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(FRAME_LINES - 1);

   logic [TICK_W-1:0] tick_q;
   logic [LINE_W-1:0] line_q;
   logic              fs_q;
   logic [LINE_W-1:0] li_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         tick_q <= '0;
         line_q <= '0;
         fs_q   <= 1'b0;
         li_q   <= '0;
      end else begin
         if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
         end else begin
            tick_q <= tick_q + 1'b1;
         end
         fs_q <= (tick_q == '0) && (line_q == '0);
         li_q <= line_q;
      end
   end

   assign tick_o        = tick_q;
   assign xfer_line_o   = (line_q == '0);
   assign readout_o     = (line_q != '0) && (tick_q >= RET_T);
   assign frame_start_o = fs_q;
   assign line_index_o  = li_q;

   AST_TICK_RANGE: assert property (@(posedge clk) disable iff (srst)
      tick_q <= TICK_LAST); // R2
   AST_LINE_RANGE: assert property (@(posedge clk) disable iff (srst)
      line_q <= LINE_LAST); // R2
   AST_LINE_STEP: assert property (@(posedge clk) disable iff (srst)
      (li_q != $past(li_q)) |-> (li_q == $past(li_q) + 1'b1 || li_q == '0)); // R2

endmodule

// File: rtl/ccd_vert_gen.sv
module ccd_vert_gen
   import ccd_seq_pkg::*;
#(
   parameter int TICK_W = 12,
   parameter int VD     = 12,
   parameter int VT     = 160,
   parameter int PED    = 573,
   parameter int VH     = 974
) (
   input  logic              clk,
   input  logic              srst,
   input  logic [TICK_W-1:0] tick_i,
   input  logic              xfer_line_i,
   output vphase_t           v_o
);

   localparam logic [TICK_W-1:0] VT_BEG = TICK_W'(VD);
   localparam logic [TICK_W-1:0] VT_END = TICK_W'(VD + VT);
   localparam logic [TICK_W-1:0] HI_BEG = TICK_W'(PED);
   localparam logic [TICK_W-1:0] HI_END = TICK_W'(PED + VH);
   localparam logic [TICK_W-1:0] VH_T   = TICK_W'(VH);

   vphase_t v_d, v_q;
   logic    row_win, hi_win;

   assign row_win = (tick_i >= VT_BEG) && (tick_i < VT_END);
   assign hi_win  = (tick_i >= HI_BEG) && (tick_i < HI_END);

   always_comb begin
      v_d = V_IDLE;
      if (xfer_line_i) begin
         v_d.v2_hi = hi_win;
      end else begin
         v_d.v1    = row_win;
         v_d.v2_on = ~row_win;
      end
   end

   always_ff @(posedge clk) begin
      if (srst) v_q <= V_IDLE;
      else      v_q <= v_d;
   end

   assign v_o = v_q;

   // Checker-side run length of the high transfer level
   logic [TICK_W-1:0] hi_run_q;
   always_ff @(posedge clk) begin
      if (srst)          hi_run_q <= '0;
      else if (v_q.v2_hi) hi_run_q <= hi_run_q + 1'b1;
      else               hi_run_q <= '0;
   end

   AST_V_COMPL: assert property (@(posedge clk) disable iff (srst)
      v_q.v1 != v_q.v2_on); // R3
   AST_HI_ON: assert property (@(posedge clk) disable iff (srst)
      v_q.v2_hi |-> (v_q.v2_on && !v_q.v1)); // R4
   AST_HI_LEN: assert property (@(posedge clk) disable iff (srst)
      $fell(v_q.v2_hi) |-> (hi_run_q == VH_T)); // R4

endmodule

// File: rtl/ccd_horiz_gen.sv
module ccd_horiz_gen
   import ccd_seq_pkg::*;
#(
   parameter int TPP      = 4,
   parameter int RST_W    = 1,
   parameter int H_PIX    = 791,
   localparam int SUB_W   = $clog2(TPP),
   localparam int PIX_W   = $clog2(H_PIX)
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             readout_i,
   output hphase_t          h_o,
   output logic             line_valid_o,
   output logic [PIX_W-1:0] pixel_o
);

   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TPP - 1);
   localparam logic [SUB_W-1:0] HALF_S   = SUB_W'(TPP / 2);
   localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(H_PIX - 1);

   logic [SUB_W-1:0] sub_q;
   logic [PIX_W-1:0] pix_q;

   // Position within the readout of the tick now being decoded
   always_ff @(posedge clk) begin
      if (srst || !readout_i) begin
         sub_q <= '0;
         pix_q <= '0;
      end else if (sub_q == SUB_LAST) begin
         sub_q <= '0;
         pix_q <= (pix_q == PIX_LAST) ? '0 : pix_q + 1'b1;
      end else begin
         sub_q <= sub_q + 1'b1;
      end
   end

   logic h1_d, rg_d;
   assign h1_d = !readout_i || (sub_q < HALF_S);

   generate
      if (RST_W == TPP / 2) begin : g_rg_half
         // Gate spans the whole phase-2 half; its end would not fit SUB_W
         assign rg_d = !h1_d;
      end else begin : g_rg_part
         localparam logic [SUB_W-1:0] RG_END = SUB_W'(TPP / 2 + RST_W);
         assign rg_d = readout_i && (sub_q >= HALF_S) && (sub_q < RG_END);
      end
   endgenerate

   hphase_t          h_q;
   logic             lv_q;
   logic [PIX_W-1:0] px_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         h_q  <= H_IDLE;
         lv_q <= 1'b0;
         px_q <= '0;
      end else begin
         h_q  <= '{h1: h1_d, h2: !h1_d, rg: rg_d};
         lv_q <= readout_i;
         px_q <= readout_i ? pix_q : '0;
      end
   end

   assign h_o          = h_q;
   assign line_valid_o = lv_q;
   assign pixel_o      = px_q;

   AST_H_COMPL: assert property (@(posedge clk) disable iff (srst)
      h_q.h1 != h_q.h2); // R5
   AST_RG_IN_H2: assert property (@(posedge clk) disable iff (srst)
      h_q.rg |-> (h_q.h2 && lv_q)); // R6
   AST_RG_START: assert property (@(posedge clk) disable iff (srst)
      $rose(h_q.rg) |-> $rose(h_q.h2)); // R6
   AST_PIX_RANGE: assert property (@(posedge clk) disable iff (srst)
      px_q <= PIX_LAST); // R7
   AST_PIX_STEP: assert property (@(posedge clk) disable iff (srst)
      (lv_q && $past(lv_q)) |-> (px_q == $past(px_q) || px_q == $past(px_q) + 1'b1)); // R7

endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
   import ccd_seq_pkg::*;
#(
   parameter int TPP         = 4,
   parameter int RST_W       = 1,
   parameter int H_PIX       = 791,
   parameter int RETRACE     = 480,
   parameter int VD          = 12,
   parameter int VT          = 160,
   parameter int HD          = 304,
   parameter int FRAME_LINES = 525,
   parameter int PED         = 573,
   parameter int VH          = 974,
   localparam int LINE_TICKS = RETRACE + H_PIX * TPP,
   localparam int TICK_W     = $clog2(LINE_TICKS),
   localparam int LINE_W     = $clog2(FRAME_LINES),
   localparam int PIX_W      = $clog2(H_PIX)
) (
   input  logic             clk,
   input  logic             srst,
   output logic             v1_on_o,
   output logic             v2_on_o,
   output logic             v2_hi_o,
   output logic             h1_on_o,
   output logic             h2_on_o,
   output logic             rg_on_o,
   output logic             frame_start_o,
   output logic             line_valid_o,
   output logic [PIX_W-1:0] pixel_index_o,
   output logic [LINE_W-1:0] line_index_o
);

   // Elaboration-time parameter checks (R9)
   if (TPP < 2 || (TPP % 2) != 0) begin : g_bad_tpp
      $error("TPP must be even and at least 2");
   end
   if (RST_W < 1 || RST_W > TPP / 2) begin : g_bad_rst
      $error("RST_W must lie in 1..TPP/2");
   end
   if (VT < 1 || VH < 1 || HD < 0 || VD < 0) begin : g_bad_len
      $error("transfer lengths must be positive");
   end
   if (VD + VT + HD > RETRACE) begin : g_bad_retrace
      $error("retrace too short for vertical delay, transfer and horizontal delay");
   end
   if (2 * PED + VH > LINE_TICKS) begin : g_bad_ped
      $error("photodiode transfer pulse and pedestals exceed one line");
   end
   if (FRAME_LINES < 2 || H_PIX < 2) begin : g_bad_size
      $error("frame needs at least two lines and two pixels");
   end

   logic [TICK_W-1:0] tick;
   logic              xfer_line, readout;
   vphase_t           vph;
   hphase_t           hph;

   ccd_line_timer #(
      .LINE_TICKS (LINE_TICKS),
      .FRAME_LINES(FRAME_LINES),
      .RETRACE    (RETRACE)
   ) u_timer (
      .clk          (clk),
      .srst         (srst),
      .tick_o       (tick),
      .xfer_line_o  (xfer_line),
      .readout_o    (readout),
      .frame_start_o(frame_start_o),
      .line_index_o (line_index_o)
   );

   ccd_vert_gen #(
      .TICK_W(TICK_W),
      .VD    (VD),
      .VT    (VT),
      .PED   (PED),
      .VH    (VH)
   ) u_vert (
      .clk        (clk),
      .srst       (srst),
      .tick_i     (tick),
      .xfer_line_i(xfer_line),
      .v_o        (vph)
   );

   ccd_horiz_gen #(
      .TPP  (TPP),
      .RST_W(RST_W),
      .H_PIX(H_PIX)
   ) u_horiz (
      .clk         (clk),
      .srst        (srst),
      .readout_i   (readout),
      .h_o         (hph),
      .line_valid_o(line_valid_o),
      .pixel_o     (pixel_index_o)
   );

   assign v1_on_o = vph.v1;
   assign v2_on_o = vph.v2_on;
   assign v2_hi_o = vph.v2_hi;
   assign h1_on_o = hph.h1;
   assign h2_on_o = hph.h2;
   assign rg_on_o = hph.rg;

   // Ticks since vertical phase 1 last fell, saturating (checker only)
   localparam logic [TICK_W-1:0] HD_T = TICK_W'(HD);
   logic [TICK_W-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (srst || v1_on_o)  gap_q <= srst ? '1 : '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
   end

   AST_NO_HSHIFT_IN_VXFER: assert property (@(posedge clk) disable iff (srst)
      v1_on_o |-> (h1_on_o && !h2_on_o && !line_valid_o)); // R8
   AST_HD_GAP: assert property (@(posedge clk) disable iff (srst)
      $rose(line_valid_o) |-> (gap_q >= HD_T)); // R8
   AST_FS_LINE0: assert property (@(posedge clk) disable iff (srst)
      frame_start_o |-> (line_index_o == '0)); // R2
   AST_HI_LINE0: assert property (@(posedge clk) disable iff (srst)
      v2_hi_o |-> (line_index_o == '0)); // R4
   AST_NO_READ_LINE0: assert property (@(posedge clk) disable iff (srst)
      (line_index_o == '0) |-> !line_valid_o); // R4

endmodule

// File: tb/ccd_clk_seq_tb.sv
`timescale 1ns/1ps
module ccd_clk_seq_tb;

   localparam int TPP = 4, RST_W = 1, H_PIX = 10, RETRACE = 16;
   localparam int VD = 2, VT = 5, HD = 6, FL = 6, PED = 4, VH = 9;
   localparam int LINE = RETRACE + H_PIX * TPP;
   localparam int PIX_W = $clog2(H_PIX), LINE_W = $clog2(FL);

   logic clk = 1'b0;
   logic srst = 1'b1;
   logic v1, v2, vhi, h1, h2, rg, fs, lv;
   logic [PIX_W-1:0]  px;
   logic [LINE_W-1:0] li;

   always #2.5 clk = ~clk;

   ccd_clk_seq #(
      .TPP(TPP), .RST_W(RST_W), .H_PIX(H_PIX), .RETRACE(RETRACE), .VD(VD),
      .VT(VT), .HD(HD), .FRAME_LINES(FL), .PED(PED), .VH(VH)
   ) u_dut (
      .clk(clk), .srst(srst), .v1_on_o(v1), .v2_on_o(v2), .v2_hi_o(vhi),
      .h1_on_o(h1), .h2_on_o(h2), .rg_on_o(rg), .frame_start_o(fs),
      .line_valid_o(lv), .pixel_index_o(px), .line_index_o(li)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: position counters and expected output levels
   int t = 0, l = 0;
   bit in_rst = 1'b1, started = 1'b0;
   int e_v1, e_v2, e_hi, e_h1, e_h2, e_rg, e_fs, e_lv, e_px, e_li;

   task automatic set_idle();
      e_v1 = 0; e_v2 = 1; e_hi = 0; e_h1 = 1; e_h2 = 0; e_rg = 0;
      e_fs = 0; e_lv = 0; e_px = 0; e_li = 0;
   endtask

   task automatic predict(input int tt, input int ll);
      set_idle();
      e_fs = (ll == 0 && tt == 0) ? 1 : 0;
      e_li = ll;
      if (ll == 0) begin
         e_hi = (tt >= PED && tt < PED + VH) ? 1 : 0;
      end else begin
         e_v1 = (tt >= VD && tt < VD + VT) ? 1 : 0;
         e_v2 = 1 - e_v1;
         if (tt >= RETRACE) begin
            int r = tt - RETRACE;
            int s = r % TPP;
            e_lv = 1;
            e_px = r / TPP;
            e_h1 = (s < TPP / 2) ? 1 : 0;
            e_h2 = 1 - e_h1;
            e_rg = (s >= TPP / 2 && s < TPP / 2 + RST_W) ? 1 : 0;
         end
      end
   endtask

   always @(posedge clk) begin
      started <= 1'b1;
      if (srst) begin
         in_rst = 1'b1;
         t = 0; l = 0;
         set_idle();
      end else begin
         in_rst = 1'b0;
         predict(t, l);
         t++;
         if (t == LINE) begin
            t = 0;
            l = (l + 1) % FL;
         end
      end
   end

   // Totals: frame period and photodiode-pulse width
   int cyc = 0, last_fs = -1, hi_cnt = 0;

   always @(negedge clk) begin
      if (started && !done) begin
         cyc++;
         if (in_rst) begin
            chk("R1", "v1", v1, 0);  chk("R1", "v2_on", v2, 1); chk("R1", "v2_hi", vhi, 0);
            chk("R1", "h1", h1, 1);  chk("R1", "h2", h2, 0);    chk("R1", "rg", rg, 0);
            chk("R1", "frame_start", fs, 0); chk("R1", "line_valid", lv, 0);
            chk("R1", "pixel_index", int'(px), 0); chk("R1", "line_index", int'(li), 0);
            last_fs = -1; hi_cnt = 0;
         end else begin
            chk("R3", "v1", v1, e_v1);        chk("R3", "v2_on", v2, e_v2);
            chk("R4", "v2_hi", vhi, e_hi);
            chk("R5", "h1", h1, e_h1);        chk("R5", "h2", h2, e_h2);
            chk("R6", "rg", rg, e_rg);
            chk("R2", "frame_start", fs, e_fs); chk("R2", "line_index", int'(li), e_li);
            chk("R7", "line_valid", lv, e_lv);  chk("R7", "pixel_index", int'(px), e_px);
            if (v1) chk("R8", "hclk during vertical transfer", int'(h2) + int'(lv), 0);
            if (fs) begin
               if (last_fs >= 0) begin
                  chk("R2", "frame period", cyc - last_fs, FL * LINE);
                  chk("R4", "v2_hi ticks per frame", hi_cnt, VH);
               end
               last_fs = cyc;
               hi_cnt = 0;
            end
            if (vhi) hi_cnt++;
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      srst = 1'b0;
      repeat (2 * FL * LINE + 37) @(negedge clk);
      srst = 1'b1;                       // mid-line reset
      repeat (3) @(negedge clk);
      srst = 1'b0;
      repeat (FL * LINE + 60) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule